// File: doc/BRIEF.md
# Network-to-AXI Subordinate Bridge

This block sits at one endpoint of an on-chip packet network and turns the single-flit request packets that arrive there into AXI4 manager transactions toward a local memory or device. It peeks at the head of the receive queue. A write-address or read-address request at the head is replayed as an address handshake. For a write, the following data flits are passed on one beat at a time. When the subordinate answers, its write response or each read beat is packed into a response flit and launched on the send port. The return destination comes from the low bits of the request ID.

The bridge handles one transaction at a time. A flit leaves the receive queue only in the cycle of the AXI handshake that uses it, so the queue head stays visible and stable until then. The response readies toward the subordinate are raised only when the send port can take a flit in that same cycle, so no response storage is needed.

Top module: `nbr_axi_sub_bridge`

## Requirements
- R1: While reset is held (synchronous, active low), all valid and ready outputs toward the subordinate, the dequeue strobe and the send flit are all zero.
- R2: A valid head flit (bit 96 set) with channel code 001 in payload bits [91:89], seen while idle, raises the write-address valid in the next cycle. The address fields are decoded from the flit: len [76:69], size [68:66], burst [65:64], lock [63], cache [62:59], prot [58:56], qos [55:52], region [51:48], addr [47:16], user [15:8], id [7:0]. Valid is held until ready, and the flit is dequeued in the handshake cycle.
- R3: A valid head flit with channel code 010, seen while idle, does the same on the read-address channel, with the same field positions.
- R4: A valid head flit with any other channel code seen while idle is not consumed. No address valid is raised, nothing is dequeued and no flit is sent, for as long as the flit stays at the head.
- R5: After a write address is accepted, each valid head flit is presented as a W beat: last [88], strb [87:80], data [79:16], user [15:8]. It is dequeued in its handshake cycle. The beat with last set ends the data phase.
- R6: The write-response ready is high only while the send port is ready. In the response handshake cycle a flit is sent with bit 96 valid, bit 95 set, bits [94:93] the low two bits of the request ID, bit 92 the virtual channel (0), and payload code 101, resp at [81:80], and the request's user and id at [15:8] and [7:0].
- R7: The read-data ready is high only while the send port is ready. Each read handshake sends a flit with the same header, code 110, last at [88], resp at [81:80], data at [79:16], and the request's user and id.
- R8: The bridge returns to idle (no valid or ready asserted) in the cycle after the write response handshake, or after the read beat with last set.
- R9: No new address handshake is offered while a transaction is in progress.
- R10: The receive queue is dequeued only in a cycle with an AW, AR or W handshake, and exactly once per consumed flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_flit | input | 97 | Head of the receive queue, bit 96 = valid |
| rx_deq | output | 1 | Pops the receive queue head |
| tx_flit | output | 97 | Outgoing response flit, bit 96 = valid |
| tx_ready | input | 1 | Send port can accept a flit this cycle |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awid | output | 8 | Write ID |
| m_awaddr | output | 32 | Write address |
| m_awlen | output | 8 | Write burst length |
| m_awsize | output | 3 | Write beat size |
| m_awburst | output | 2 | Write burst type |
| m_awlock | output | 1 | Write lock |
| m_awcache | output | 4 | Write cache attributes |
| m_awprot | output | 3 | Write protection |
| m_awqos | output | 4 | Write QoS |
| m_awregion | output | 4 | Write region |
| m_awuser | output | 8 | Write address user |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | 64 | Write data |
| m_wstrb | output | 8 | Write byte strobes |
| m_wlast | output | 1 | Last write beat |
| m_wuser | output | 8 | Write data user |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_arid | output | 8 | Read ID |
| m_araddr | output | 32 | Read address |
| m_arlen | output | 8 | Read burst length |
| m_arsize | output | 3 | Read beat size |
| m_arburst | output | 2 | Read burst type |
| m_arlock | output | 1 | Read lock |
| m_arcache | output | 4 | Read cache attributes |
| m_arprot | output | 3 | Read protection |
| m_arqos | output | 4 | Read QoS |
| m_arregion | output | 4 | Read region |
| m_aruser | output | 8 | Read address user |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | 64 | Read data |
| m_rresp | input | 2 | Read response code |
| m_rlast | input | 1 | Last read beat |

## Verification
The embedded properties watch the handshake discipline on every cycle. Address valids must hold until ready, at most one channel may be active at once, and response readies must follow the send port. Nothing may be dequeued while idle, an unknown code must keep the bridge idle, and a flit may be sent only in a response handshake. Only the bench's scenarios can show that the decoded fields and the packed response flits are bit-exact, and that the ID and user are taken from the request and not from the subordinate. They also show that every flit of a mixed random stream is consumed exactly once, and that a flit with a foreign code stays at the head untouched.

// File: rtl/nbr_pkg.sv
// Shared field layout, channel codes and state encoding for the
// network-to-AXI subordinate bridge. Assumes the 92-bit payload layout
// with id/user packed in the low 16 bits of every flit.
package nbr_pkg;

    localparam int PAY_W   = 92;
    localparam int CODE_W  = 3;
    localparam int CODE_LSB = PAY_W - CODE_W;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 64;
    localparam int STRB_W  = DATA_W / 8;
    localparam int ID_W    = 8;
    localparam int USER_W  = 8;
    localparam int LEN_W   = 8;
    localparam int RESP_W  = 2;

    // Response field positions inside the payload
    localparam int RSP_RESP_LSB = 80;
    localparam int RSP_LAST_BIT = 88;
    localparam int RSP_DATA_LSB = 16;
    localparam int RSP_USER_LSB = 8;
    localparam int RSP_ID_LSB   = 0;

    localparam logic [CODE_W-1:0] CODE_AW = 3'b001;
    localparam logic [CODE_W-1:0] CODE_AR = 3'b010;
    localparam logic [CODE_W-1:0] CODE_B  = 3'b101;
    localparam logic [CODE_W-1:0] CODE_R  = 3'b110;

    // Address request fields, MSB first, occupying payload [76:0]
    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [2:0]        size;
        logic [1:0]        burst;
        logic              lock;
        logic [3:0]        cache;
        logic [2:0]        prot;
        logic [3:0]        qos;
        logic [3:0]        region;
        logic [ADDR_W-1:0] addr;
        logic [USER_W-1:0] user;
        logic [ID_W-1:0]   id;
    } addr_req_t;

    // Write beat fields, MSB first, occupying payload [88:0]
    typedef struct packed {
        logic              last;
        logic [STRB_W-1:0] strb;
        logic [DATA_W-1:0] data;
        logic [USER_W-1:0] user;
        logic [ID_W-1:0]   id;
    } wr_beat_t;

    localparam int AREQ_W = $bits(addr_req_t);
    localparam int WBEAT_W = $bits(wr_beat_t);

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WADDR  = 3'd1,
        ST_WWAIT  = 3'd2,
        ST_WBEAT  = 3'd3,
        ST_WRESP  = 3'd4,
        ST_RADDR  = 3'd5,
        ST_RDATA  = 3'd6
    } br_state_t;

endpackage

// File: rtl/nbr_rx_decode.sv
// Splits the receive-queue head flit into valid flag, channel code and
// the address-request and write-beat views. Purely combinational;
// assumes the valid flag is the flit MSB and the payload sits at the LSBs.
module nbr_rx_decode
    import nbr_pkg::*;
#(
    parameter int FLIT_W = 97
) (
    input  logic [FLIT_W-1:0] rx_flit,
    output logic              head_vld,
    output logic [CODE_W-1:0] head_code,
    output addr_req_t         head_areq,
    output wr_beat_t          head_wbeat
);

    logic [FLIT_W-PAY_W-2:0] unused_hdr;
    logic [PAY_W-1:0]        pay;

    // Field extraction from the head flit
    always_comb begin
        head_vld   = rx_flit[FLIT_W-1];
        unused_hdr = rx_flit[FLIT_W-2:PAY_W];
        pay        = rx_flit[PAY_W-1:0];
        head_code  = pay[CODE_LSB +: CODE_W];
        head_areq  = addr_req_t'(pay[AREQ_W-1:0]);
        head_wbeat = wr_beat_t'(pay[WBEAT_W-1:0]);
    end

endmodule

// File: rtl/nbr_ctrl.sv
// Transaction sequencer: one request at a time, peek-style receive queue.
// Assumes the head flit stays stable until rx_deq, and that tx_ready
// means the send port accepts a flit in the same cycle.
module nbr_ctrl
    import nbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_vld,
    input  logic [CODE_W-1:0] head_code,
    input  logic [ID_W-1:0]   head_id,
    input  logic [USER_W-1:0] head_user,
    input  logic              head_wlast,
    input  logic              awready,
    input  logic              arready,
    input  logic              wready,
    input  logic              bvalid,
    input  logic              rvalid,
    input  logic              rlast,
    input  logic              tx_ready,
    output logic              awvalid,
    output logic              arvalid,
    output logic              wvalid,
    output logic              bready,
    output logic              rready,
    output logic              rx_deq,
    output logic              b_fire,
    output logic              r_fire,
    output logic [ID_W-1:0]   rsp_id,
    output logic [USER_W-1:0] rsp_user
);

    br_state_t state, state_nx;
    logic aw_fire, ar_fire, w_fire;

    // Channel strobes decoded from the current state
    always_comb begin
        awvalid = (state == ST_WADDR);
        arvalid = (state == ST_RADDR);
        wvalid  = (state == ST_WBEAT);
        bready  = (state == ST_WRESP) && tx_ready;
        rready  = (state == ST_RDATA) && tx_ready;
        aw_fire = awvalid && awready;
        ar_fire = arvalid && arready;
        w_fire  = wvalid && wready;
        b_fire  = bready && bvalid;
        r_fire  = rready && rvalid;
        rx_deq  = aw_fire || ar_fire || w_fire;
    end

    // Next-state selection
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: begin
                if (head_vld && head_code == CODE_AW)      state_nx = ST_WADDR;
                else if (head_vld && head_code == CODE_AR) state_nx = ST_RADDR;
            end
            ST_WADDR: if (aw_fire) state_nx = ST_WWAIT;
            ST_WWAIT: if (head_vld) state_nx = ST_WBEAT;
            ST_WBEAT: if (w_fire) state_nx = head_wlast ? ST_WRESP : ST_WWAIT;
            ST_WRESP: if (b_fire) state_nx = ST_IDLE;
            ST_RADDR: if (ar_fire) state_nx = ST_RDATA;
            ST_RDATA: if (r_fire && rlast) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Capture of requester ID and user for the response flits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_id   <= '0;
            rsp_user <= '0;
        end else if (aw_fire || ar_fire) begin
            rsp_id   <= head_id;
            rsp_user <= head_user;
        end
    end

    // Address valid must persist until accepted
    p_aw_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid && !awready |=> awvalid);
    p_ar_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid && !arready |=> arvalid);

    // Unknown code at the head keeps the bridge idle without consuming
    p_idle_no_deq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !rx_deq);
    p_foreign_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) && head_vld && (head_code != CODE_AW) && (head_code != CODE_AR)
        |=> (state == ST_IDLE));

    // Response readies only when the send port can take the flit
    p_bready_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bready |-> tx_ready);
    p_rready_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rready |-> tx_ready);

    // Return to idle after the closing response
    p_rlast_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_fire && rlast |=> (state == ST_IDLE));
    p_bdone_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        b_fire |=> (state == ST_IDLE));

    // Single active channel at any time
    p_one_channel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({awvalid, arvalid, wvalid, bready, rready}));

endmodule

// File: rtl/nbr_tx_pack.sv
// Builds the outgoing response flit in the cycle of a B or R handshake.
// Assumes at most one of b_fire / r_fire is high; outputs all-zero when
// neither is. Destination is the low bits of the captured request ID.
module nbr_tx_pack
    import nbr_pkg::*;
#(
    parameter int DEST_W = 2,
    parameter int VC_W   = 1,
    parameter int VC_SEL = 0,
    parameter int FLIT_W = 2 + DEST_W + VC_W + PAY_W
) (
    input  logic              b_fire,
    input  logic              r_fire,
    input  logic [RESP_W-1:0] bresp,
    input  logic [RESP_W-1:0] rresp,
    input  logic [DATA_W-1:0] rdata,
    input  logic              rlast,
    input  logic [ID_W-1:0]   rsp_id,
    input  logic [USER_W-1:0] rsp_user,
    output logic [FLIT_W-1:0] tx_flit
);

    localparam logic [VC_W-1:0] VC_VAL = VC_W'(VC_SEL);

    logic [DEST_W-1:0] dest;
    logic [PAY_W-1:0]  pay;

    // Destination derived from the requester ID
    generate
        if (DEST_W <= ID_W) begin : g_dest_slice
            assign dest = rsp_id[DEST_W-1:0];
        end else begin : g_dest_ext
            assign dest = DEST_W'(rsp_id);
        end
    endgenerate

    // Payload assembly by response type
    always_comb begin
        pay = '0;
        pay[RSP_ID_LSB +: ID_W]     = rsp_id;
        pay[RSP_USER_LSB +: USER_W] = rsp_user;
        if (r_fire) begin
            pay[CODE_LSB +: CODE_W]      = CODE_R;
            pay[RSP_LAST_BIT]            = rlast;
            pay[RSP_RESP_LSB +: RESP_W]  = rresp;
            pay[RSP_DATA_LSB +: DATA_W]  = rdata;
        end else begin
            pay[CODE_LSB +: CODE_W]      = CODE_B;
            pay[RSP_RESP_LSB +: RESP_W]  = bresp;
        end
    end

    // Flit framing: valid, single-flit tail, destination, VC, payload
    always_comb begin
        if (b_fire || r_fire) tx_flit = {1'b1, 1'b1, dest, VC_VAL, pay};
        else                  tx_flit = '0;
    end

endmodule

// File: rtl/nbr_axi_sub_bridge.sv
// Top level: receive-queue flits in, AXI4 manager port out toward a
// subordinate, response flits back on the send port. One transaction in
// flight; no buffering at either edge.
module nbr_axi_sub_bridge
    import nbr_pkg::*;
#(
    parameter int DEST_W = 2,
    parameter int VC_W   = 1,
    parameter int VC_SEL = 0,
    parameter int FLIT_W = 2 + DEST_W + VC_W + PAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLIT_W-1:0] rx_flit,
    output logic              rx_deq,
    output logic [FLIT_W-1:0] tx_flit,
    input  logic              tx_ready,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [ID_W-1:0]   m_awid,
    output logic [ADDR_W-1:0] m_awaddr,
    output logic [LEN_W-1:0]  m_awlen,
    output logic [2:0]        m_awsize,
    output logic [1:0]        m_awburst,
    output logic              m_awlock,
    output logic [3:0]        m_awcache,
    output logic [2:0]        m_awprot,
    output logic [3:0]        m_awqos,
    output logic [3:0]        m_awregion,
    output logic [USER_W-1:0] m_awuser,
    output logic              m_wvalid,
    input  logic              m_wready,
    output logic [DATA_W-1:0] m_wdata,
    output logic [STRB_W-1:0] m_wstrb,
    output logic              m_wlast,
    output logic [USER_W-1:0] m_wuser,
    input  logic              m_bvalid,
    output logic              m_bready,
    input  logic [RESP_W-1:0] m_bresp,
    output logic              m_arvalid,
    input  logic              m_arready,
    output logic [ID_W-1:0]   m_arid,
    output logic [ADDR_W-1:0] m_araddr,
    output logic [LEN_W-1:0]  m_arlen,
    output logic [2:0]        m_arsize,
    output logic [1:0]        m_arburst,
    output logic              m_arlock,
    output logic [3:0]        m_arcache,
    output logic [2:0]        m_arprot,
    output logic [3:0]        m_arqos,
    output logic [3:0]        m_arregion,
    output logic [USER_W-1:0] m_aruser,
    input  logic              m_rvalid,
    output logic              m_rready,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic [RESP_W-1:0] m_rresp,
    input  logic              m_rlast
);

    logic              head_vld;
    logic [CODE_W-1:0] head_code;
    addr_req_t         head_areq;
    wr_beat_t          head_wbeat;
    logic              b_fire, r_fire;
    logic [ID_W-1:0]   rsp_id;
    logic [USER_W-1:0] rsp_user;
    logic [ID_W-1:0]   unused_wid;

    nbr_rx_decode #(.FLIT_W(FLIT_W)) u_dec (
        .rx_flit    (rx_flit),
        .head_vld   (head_vld),
        .head_code  (head_code),
        .head_areq  (head_areq),
        .head_wbeat (head_wbeat)
    );

    nbr_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_vld   (head_vld),
        .head_code  (head_code),
        .head_id    (head_areq.id),
        .head_user  (head_areq.user),
        .head_wlast (head_wbeat.last),
        .awready    (m_awready),
        .arready    (m_arready),
        .wready     (m_wready),
        .bvalid     (m_bvalid),
        .rvalid     (m_rvalid),
        .rlast      (m_rlast),
        .tx_ready   (tx_ready),
        .awvalid    (m_awvalid),
        .arvalid    (m_arvalid),
        .wvalid     (m_wvalid),
        .bready     (m_bready),
        .rready     (m_rready),
        .rx_deq     (rx_deq),
        .b_fire     (b_fire),
        .r_fire     (r_fire),
        .rsp_id     (rsp_id),
        .rsp_user   (rsp_user)
    );

    nbr_tx_pack #(
        .DEST_W (DEST_W),
        .VC_W   (VC_W),
        .VC_SEL (VC_SEL),
        .FLIT_W (FLIT_W)
    ) u_pack (
        .b_fire   (b_fire),
        .r_fire   (r_fire),
        .bresp    (m_bresp),
        .rresp    (m_rresp),
        .rdata    (m_rdata),
        .rlast    (m_rlast),
        .rsp_id   (rsp_id),
        .rsp_user (rsp_user),
        .tx_flit  (tx_flit)
    );

    // Address channel fan-out: both channels share the decoded head view
    always_comb begin
        m_awid     = head_areq.id;     m_arid     = head_areq.id;
        m_awaddr   = head_areq.addr;   m_araddr   = head_areq.addr;
        m_awlen    = head_areq.len;    m_arlen    = head_areq.len;
        m_awsize   = head_areq.size;   m_arsize   = head_areq.size;
        m_awburst  = head_areq.burst;  m_arburst  = head_areq.burst;
        m_awlock   = head_areq.lock;   m_arlock   = head_areq.lock;
        m_awcache  = head_areq.cache;  m_arcache  = head_areq.cache;
        m_awprot   = head_areq.prot;   m_arprot   = head_areq.prot;
        m_awqos    = head_areq.qos;    m_arqos    = head_areq.qos;
        m_awregion = head_areq.region; m_arregion = head_areq.region;
        m_awuser   = head_areq.user;   m_aruser   = head_areq.user;
    end

    // Write beat fan-out
    always_comb begin
        m_wdata    = head_wbeat.data;
        m_wstrb    = head_wbeat.strb;
        m_wlast    = head_wbeat.last;
        m_wuser    = head_wbeat.user;
        unused_wid = head_wbeat.id;
    end

    // A flit is sent only in a response handshake cycle
    p_tx_on_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flit[FLIT_W-1] |-> (m_bvalid && m_bready) || (m_rvalid && m_rready));

    // Dequeue coincides with a consuming handshake
    p_deq_hs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_deq |-> (m_awvalid && m_awready) || (m_arvalid && m_arready)
                   || (m_wvalid && m_wready));

    // Write beats are only offered with a flit at the head
    p_wbeat_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid |-> rx_flit[FLIT_W-1]);

endmodule

// File: tb/tb_nbr_axi_sub_bridge.sv
// Self-checking bench: random read/write request stream plus directed
// reset and foreign-code cases, with a subordinate model and a
// response-flit reference built from the requirements.
module tb_nbr_axi_sub_bridge;

    localparam int CLK_P = 10;
    localparam int NTX   = 40;
    localparam int QD    = 256;
    localparam int LIMIT = 20000;

    logic clk = 1'b0;
    logic rst_n;
    always #(CLK_P/2) clk = ~clk;

    logic [96:0] rx_flit, tx_flit;
    logic rx_deq, tx_ready;
    logic m_awvalid, m_awready, m_awlock;
    logic [7:0] m_awid, m_awlen, m_awuser;
    logic [31:0] m_awaddr;
    logic [2:0] m_awsize, m_awprot;
    logic [1:0] m_awburst;
    logic [3:0] m_awcache, m_awqos, m_awregion;
    logic m_wvalid, m_wready, m_wlast;
    logic [63:0] m_wdata;
    logic [7:0] m_wstrb, m_wuser;
    logic m_bvalid, m_bready;
    logic [1:0] m_bresp;
    logic m_arvalid, m_arready, m_arlock;
    logic [7:0] m_arid, m_arlen, m_aruser;
    logic [31:0] m_araddr;
    logic [2:0] m_arsize, m_arprot;
    logic [1:0] m_arburst;
    logic [3:0] m_arcache, m_arqos, m_arregion;
    logic m_rvalid, m_rready, m_rlast;
    logic [63:0] m_rdata;
    logic [1:0] m_rresp;

    nbr_axi_sub_bridge dut (
        .clk(clk), .rst_n(rst_n), .rx_flit(rx_flit), .rx_deq(rx_deq),
        .tx_flit(tx_flit), .tx_ready(tx_ready),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awid(m_awid),
        .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize),
        .m_awburst(m_awburst), .m_awlock(m_awlock), .m_awcache(m_awcache),
        .m_awprot(m_awprot), .m_awqos(m_awqos), .m_awregion(m_awregion),
        .m_awuser(m_awuser),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
        .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wuser(m_wuser),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
        .m_arvalid(m_arvalid), .m_arready(m_arready), .m_arid(m_arid),
        .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
        .m_arburst(m_arburst), .m_arlock(m_arlock), .m_arcache(m_arcache),
        .m_arprot(m_arprot), .m_arqos(m_arqos), .m_arregion(m_arregion),
        .m_aruser(m_aruser),
        .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata),
        .m_rresp(m_rresp), .m_rlast(m_rlast)
    );

    // Receive queue model: peek at head, pop applied on the next negedge
    logic [96:0] q [QD];
    int qh, qt;
    assign rx_flit = (qh != qt) ? q[qh] : '0;

    // Transaction table
    logic       t_rd   [NTX];
    logic [7:0] t_id   [NTX];
    logic [7:0] t_user [NTX];
    logic [7:0] t_len  [NTX];
    logic [31:0] t_addr [NTX];
    logic [63:0] t_wd  [NTX*4];

    int n_chk, n_bad;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [96:0] mk_areq(input logic rd, input logic [7:0] id,
            input logic [7:0] user, input logic [7:0] len, input logic [31:0] addr);
        logic [91:0] p = '0;
        p[91:89] = rd ? 3'b010 : 3'b001;
        p[76:69] = len;  p[68:66] = 3'd3; p[65:64] = 2'd1; p[63] = id[0];
        p[62:59] = 4'h3; p[58:56] = 3'h2; p[55:52] = id[3:0]; p[51:48] = id[7:4];
        p[47:16] = addr; p[15:8] = user; p[7:0] = id;
        return {1'b1, 1'b1, 2'b00, 1'b0, p};
    endfunction

    function automatic logic [96:0] mk_wbeat(input logic last, input logic [63:0] d,
            input logic [7:0] user, input logic [7:0] id);
        logic [91:0] p = '0;
        p[91:89] = 3'b011; p[88] = last; p[87:80] = d[7:0]; p[79:16] = d;
        p[15:8] = user; p[7:0] = id;
        return {1'b1, 1'b1, 2'b00, 1'b0, p};
    endfunction

    function automatic logic [96:0] mk_rsp(input logic rd, input logic [7:0] id,
            input logic [7:0] user, input logic [1:0] resp, input logic last,
            input logic [63:0] d);
        logic [91:0] p = '0;
        p[91:89] = rd ? 3'b110 : 3'b101;
        p[81:80] = resp; p[15:8] = user; p[7:0] = id;
        if (rd) begin
            p[88] = last; p[79:16] = d;
        end
        return {1'b1, 1'b1, id[1:0], 1'b0, p};
    endfunction

    function automatic logic [63:0] rd_word(input logic [31:0] a, input int beat);
        return {a, 32'(beat)} ^ 64'h5A5A_C3C3_0F0F_9696;
    endfunction

    initial begin
        int cur, wbeat, rbeat, cyc, hsave;
        logic pend_pop, busy, viol, idle_next, b_pend, r_act, fire_any;
        logic [1:0] bres;
        n_chk = 0; n_bad = 0; qh = 0; qt = 0;
        void'($urandom(32'd2024));
        rst_n = 1'b0; tx_ready = 1'b0;
        m_awready = 0; m_arready = 0; m_wready = 0;
        m_bvalid = 0; m_bresp = 0; m_rvalid = 0; m_rdata = '0; m_rresp = 0; m_rlast = 0;

        // Build the request stream
        for (int i = 0; i < NTX; i++) begin
            t_rd[i] = ($urandom % 2) == 1;
            t_id[i] = 8'($urandom); t_user[i] = 8'($urandom);
            t_len[i] = (i < 2) ? 8'd0 : 8'($urandom % 4);
            t_addr[i] = $urandom;
            q[qt] = mk_areq(t_rd[i], t_id[i], t_user[i], t_len[i], t_addr[i]); qt++;
            if (!t_rd[i]) begin
                for (int b = 0; b <= int'(t_len[i]); b++) begin
                    t_wd[i*4+b] = {$urandom, $urandom};
                    q[qt] = mk_wbeat(b == int'(t_len[i]), t_wd[i*4+b], 8'(b), 8'hEE); qt++;
                end
            end
        end
        hsave = qt;
        qt = 0;  // keep queue empty during reset

        repeat (3) @(negedge clk);
        #(CLK_P/4);
        // R1: reset state
        chk("R1", {m_awvalid, m_arvalid, m_wvalid, m_bready, m_rready, rx_deq, tx_flit}, '0);
        @(negedge clk);
        rst_n = 1'b1; qt = hsave;

        cur = 0; wbeat = 0; rbeat = 0; pend_pop = 0; busy = 0; viol = 0;
        idle_next = 0; b_pend = 0; r_act = 0; bres = 0;
        for (cyc = 0; cyc < LIMIT && cur < NTX; cyc++) begin
            @(negedge clk);
            if (pend_pop) qh++;
            pend_pop = 0;
            m_awready = ($urandom % 3) == 0;
            m_arready = ($urandom % 3) == 0;
            m_wready  = ($urandom % 2) == 0;
            tx_ready  = ($urandom % 4) != 0;
            m_bvalid  = b_pend; m_bresp = bres;
            m_rvalid  = r_act;
            m_rlast   = r_act && (rbeat == int'(t_len[cur]));
            m_rdata   = rd_word(t_addr[cur], rbeat);
            m_rresp   = 2'(rbeat) ^ t_id[cur][1:0];
            #(CLK_P/4);
            if (idle_next) begin
                // R8: idle after closing response
                chk("R8", {m_awvalid, m_arvalid, m_wvalid, m_bready, m_rready}, '0);
                idle_next = 0;
            end
            fire_any = (m_awvalid && m_awready) || (m_arvalid && m_arready) || (m_wvalid && m_wready);
            if (rx_deq) begin
                chk("R10", fire_any, 1'b1);
                pend_pop = 1;
            end else if (fire_any) chk("R10", 1'b0, 1'b1);
            if (busy && (m_awvalid || m_arvalid)) viol = 1;
            if (m_awvalid && m_awready) begin
                chk("R2", {m_awaddr, m_awlen, m_awid, m_awuser, m_awsize, m_awburst, m_awlock,
                           m_awcache, m_awprot, m_awqos, m_awregion, t_rd[cur]},
                    {t_addr[cur], t_len[cur], t_id[cur], t_user[cur], 3'd3, 2'd1, t_id[cur][0],
                     4'h3, 3'h2, t_id[cur][3:0], t_id[cur][7:4], 1'b0});
                busy = 1; wbeat = 0;
            end
            if (m_arvalid && m_arready) begin
                chk("R3", {m_araddr, m_arlen, m_arid, m_aruser, m_arsize, m_arburst, m_arlock,
                           m_arcache, m_arprot, m_arqos, m_arregion, t_rd[cur]},
                    {t_addr[cur], t_len[cur], t_id[cur], t_user[cur], 3'd3, 2'd1, t_id[cur][0],
                     4'h3, 3'h2, t_id[cur][3:0], t_id[cur][7:4], 1'b1});
                busy = 1; rbeat = 0; r_act = 1;
            end
            if (m_wvalid && m_wready) begin
                chk("R5", {m_wdata, m_wstrb, m_wlast, m_wuser},
                    {t_wd[cur*4+wbeat], t_wd[cur*4+wbeat][7:0], wbeat == int'(t_len[cur]), 8'(wbeat)});
                if (m_wlast) begin
                    b_pend = 1; bres = 2'($urandom);
                end
                wbeat++;
            end
            if (m_bvalid && !tx_ready) chk("R6", m_bready, 1'b0);
            if (m_rvalid && !tx_ready) chk("R7", m_rready, 1'b0);
            if (m_bvalid && m_bready) begin
                chk("R6", tx_flit, mk_rsp(1'b0, t_id[cur], t_user[cur], bres, 1'b0, 64'd0));
                chk("R9", viol, 1'b0);
                b_pend = 0; busy = 0; viol = 0; idle_next = 1; cur++;
            end else if (m_rvalid && m_rready) begin
                chk("R7", tx_flit, mk_rsp(1'b1, t_id[cur], t_user[cur], m_rresp, m_rlast, m_rdata));
                if (m_rlast) begin
                    chk("R9", viol, 1'b0);
                    r_act = 0; busy = 0; viol = 0; idle_next = 1; cur++;
                end
                rbeat++;
            end else if (tx_flit[96]) chk("R7", 1'b1, 1'b0);
        end
        if (cur < NTX) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: completed=%0d expected=%0d", cur, NTX);
        end

        // R4: foreign channel code stalls without consuming
        @(negedge clk);
        if (pend_pop) qh++;
        pend_pop = 0;
        chk("R10", {22'(qt - qh)}, 22'd0);
        q[qt] = mk_areq(1'b0, 8'h12, 8'h34, 8'd0, 32'h1000);
        q[qt][91:89] = 3'b111;
        qt++; hsave = qh;
        viol = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            m_awready = 1; m_arready = 1; m_wready = 1; tx_ready = 1;
            m_bvalid = 1; m_rvalid = 1;
            #(CLK_P/4);
            if (rx_deq || m_awvalid || m_arvalid || m_wvalid || tx_flit[96]) viol = 1;
        end
        chk("R4", {viol, 32'(qh)}, {1'b0, 32'(hsave)});
        chk("R4", rx_flit[91:89], 3'b111);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule